// File: doc/BRIEF.md
# Shared Interrupt Distributor with Per-CPU Targeting

This block keeps the per-line state of a small set of shared peripheral interrupt lines and offers each of up to eight CPU interfaces the most urgent interrupt aimed at it. Every line has an enable flag, a software-latched pending flag, an active flag, an 8-bit priority and an 8-bit CPU target mask. The lines are level-sensitive. While a line is not active, its input level counts as pending. Software can also latch a pending request of its own.

A simple word-addressed register bus sets and clears the enable and pending flags. Each flag has one write-one-to-set word and a separate write-one-to-clear word. The bus also programs priority and target through an index register, reads back a per-line status, and turns forwarding on and off globally.

Each CPU interface sees a valid flag, an interrupt number and a priority. It acknowledges the offered interrupt with a one-cycle pulse, which makes that interrupt active. It ends the interrupt with an end-of-interrupt pulse that carries the interrupt number, which makes the interrupt inactive again.

Each line runs a four-state machine held in two bits. Bit 0 of the state is the software-pending latch and bit 1 is active.

| State | Meaning |
|---|---|
| SL_IDLE | Nothing latched, not active. |
| SL_SWPEND | Software pending latched. |
| SL_ACTIVE | Acknowledged and being serviced. |
| SL_ACT_SWPEND | Active, with a new software request latched. |

The transitions are:

- ack moves SL_IDLE or SL_SWPEND to SL_ACTIVE.
- set-pending moves SL_IDLE to SL_SWPEND and SL_ACTIVE to SL_ACT_SWPEND.
- clear-pending moves SL_SWPEND to SL_IDLE and SL_ACT_SWPEND to SL_ACTIVE.
- deactivate moves SL_ACTIVE to SL_IDLE and SL_ACT_SWPEND to SL_SWPEND.

Top module: `irq_distributor`

Register words (addresses 11 to 15 read 0):

| Address | Name | Access and content |
|---|---|---|
| 0 | control | Bit 0 is forward enable. |
| 1 | type | Read only: NUM_IRQ in [7:0], NUM_CPU in [11:8]. |
| 2 | enable set | Write 1 to set. Reads the enable vector. |
| 3 | enable clear | Write 1 to clear. Reads the enable vector. |
| 4 | pending set | Write 1 to set. Reads the pending vector. |
| 5 | pending clear | Write 1 to clear. Reads the pending vector. |
| 6 | active | Read only: the active vector. |
| 7 | select | Line index for addresses 8 to 10. |
| 8 | priority | Priority of the selected line. |
| 9 | target | Target mask of the selected line. |
| 10 | status | Read only: status of the selected line. |

## Requirements
- R1: After reset every line is disabled, not pending and not active, with priority 0x7F and target mask 0x01. Forward enable is 0 and no CPU interface shows a valid interrupt.
- R2: A write to address 2 sets the enable bits where the data holds 1. A write to address 3 clears the enable bits where the data holds 1. Bits written 0 keep their value.
- R3: A write to address 4 latches software pending for each line whose data bit is 1. A write to address 5 clears that latch. The pending bit read back is the latch OR (input high AND line not active), so a pending clear leaves a high, inactive line pending.
- R4: Address 10 returns the selected line's status: bit 0 is pending, bit 1 is active, and 3 means both.
- R5: While control bit 0 is 0, no CPU interface shows a valid interrupt.
- R6: CPU c is offered a line only if bit c of that line's target mask is 1.
- R7: Each CPU is offered the forwarded, enabled, pending, non-active line with the lowest priority value. On equal priorities the lowest line number wins. The offered priority appears on the CPU's priority output.
- R8: A CPU ack pulse while its valid is high makes the offered line active and consumes its software latch. An active line is offered to no CPU, and its input level does not show as pending.
- R9: An end-of-interrupt pulse on any CPU with line number n makes line n inactive. A latched or level request then becomes pending again.
- R10: Address 1 reads NUM_IRQ in bits [7:0] and NUM_CPU in bits [11:8].
- R11: Writes to addresses 8 and 9 change only the priority and target of the line named by address 7, and reads of those addresses return them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | NUM_IRQ | Level-sensitive interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_valid | output | NUM_CPU | An interrupt is offered to CPU c |
| cpu_id | output | NUM_CPU*ID_W | Offered line number per CPU |
| cpu_prio | output | NUM_CPU*8 | Offered priority per CPU |
| cpu_ack | input | NUM_CPU | Acknowledge the offered line |
| cpu_eoi | input | NUM_CPU | End-of-interrupt strobe |
| cpu_eoi_id | input | NUM_CPU*ID_W | Line number ended per CPU |

## Verification
Each line's state machine feeds both the status word and the per-CPU offer.

A wrong state shows at the ports within the same cycle:

- A lost software latch makes the status read 0 and drops the line from the offer.
- An active flag that is never cleared after end-of-interrupt keeps the line off every CPU and reads status 2.
- An arbitration fault shows as the wrong number or priority on a CPU output while a competing line is pending.

The bench checks the status word and the CPU outputs one cycle after each write, ack or end-of-interrupt.

// File: rtl/idist_pkg.sv
package idist_pkg;
    localparam int PRIO_W = 8;
    localparam int TGT_W  = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [PRIO_W-1:0] PRIO_RESET = 8'h7F;
    localparam logic [TGT_W-1:0]  TGT_RESET  = 8'h01;

    typedef logic [PRIO_W-1:0] prio_t;

    // bit 0 = software pending latch, bit 1 = active
    typedef enum logic [1:0] {
        SL_IDLE       = 2'd0,
        SL_SWPEND     = 2'd1,
        SL_ACTIVE     = 2'd2,
        SL_ACT_SWPEND = 2'd3
    } slot_state_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 4'd0,
        RA_TYPE   = 4'd1,
        RA_EN_SET = 4'd2,
        RA_EN_CLR = 4'd3,
        RA_PD_SET = 4'd4,
        RA_PD_CLR = 4'd5,
        RA_ACTIVE = 4'd6,
        RA_SEL    = 4'd7,
        RA_PRIO   = 4'd8,
        RA_TGT    = 4'd9,
        RA_STAT   = 4'd10
    } reg_addr_e;
endpackage

// File: rtl/idist_slot.sv
module idist_slot
    import idist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             pd_set,
    input  logic             pd_clr,
    input  logic             prio_wr,
    input  logic             tgt_wr,
    input  logic [7:0]       wbyte,
    input  logic             ack,
    input  logic             deact,
    output logic             enabled,
    output logic             pending,
    output logic             active,
    output prio_t            prio,
    output logic [TGT_W-1:0] target,
    output logic [1:0]       status
);
    slot_state_e state_q, state_d;
    logic        sw_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE: begin
                if (ack)         state_d = SL_ACTIVE;
                else if (pd_set) state_d = SL_SWPEND;
            end
            SL_SWPEND: begin
                if (ack)         state_d = SL_ACTIVE;
                else if (pd_clr) state_d = SL_IDLE;
            end
            SL_ACTIVE: begin
                if (deact)       state_d = pd_set ? SL_SWPEND : SL_IDLE;
                else if (pd_set) state_d = SL_ACT_SWPEND;
            end
            SL_ACT_SWPEND: begin
                if (deact)       state_d = pd_clr ? SL_IDLE : SL_SWPEND;
                else if (pd_clr) state_d = SL_ACTIVE;
            end
            default: state_d = SL_IDLE;
        endcase
    end

    always_comb begin
        active  = (state_q == SL_ACTIVE) || (state_q == SL_ACT_SWPEND);
        sw_pend = (state_q == SL_SWPEND) || (state_q == SL_ACT_SWPEND);
        pending = sw_pend | (line & ~active);
        status  = {active, pending};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enabled <= 1'b0;
            prio    <= PRIO_RESET;
            target  <= TGT_RESET;
        end else begin
            if (en_set)      enabled <= 1'b1;
            else if (en_clr) enabled <= 1'b0;
            if (prio_wr) prio   <= wbyte;
            if (tgt_wr)  target <= wbyte;
        end
    end

    // R8
    act_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(ack));
    // R9
    act_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(deact));
    // R8
    ack_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !active);
    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> enabled);
endmodule

// File: rtl/idist_arbiter.sv
module idist_arbiter
    import idist_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      valid,
    output logic [ID_W-1:0]           win_id,
    output prio_t                     win_prio
);
    always_comb begin
        valid    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand[i] && (!valid || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                valid    = 1'b1;
                win_id   = i[ID_W-1:0];
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R7
    win_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> cand[win_id]);
    // R7
    none_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |-> !valid);
endmodule

// File: rtl/idist_regs.sv
module idist_regs
    import idist_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CPU = 4,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_IRQ-1:0] en_vec,
    input  logic [NUM_IRQ-1:0] pend_vec,
    input  logic [NUM_IRQ-1:0] act_vec,
    input  prio_t              sel_prio,
    input  logic [TGT_W-1:0]   sel_tgt,
    input  logic [1:0]         sel_stat,
    output logic               fwd_en,
    output logic [ID_W-1:0]    sel_idx,
    output logic [NUM_IRQ-1:0] en_set_v,
    output logic [NUM_IRQ-1:0] en_clr_v,
    output logic [NUM_IRQ-1:0] pd_set_v,
    output logic [NUM_IRQ-1:0] pd_clr_v,
    output logic [NUM_IRQ-1:0] prio_wr_v,
    output logic [NUM_IRQ-1:0] tgt_wr_v
);
    localparam logic [DATA_W-1:0] TYPE_VAL =
        DATA_W'((NUM_CPU % 16) * 256 + (NUM_IRQ % 256));

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_en  <= 1'b0;
            sel_idx <= '0;
        end else if (bus_wr) begin
            if (addr_e == RA_CTRL) fwd_en  <= bus_wdata[0];
            if (addr_e == RA_SEL)  sel_idx <= bus_wdata[ID_W-1:0];
        end
    end

    always_comb begin
        en_set_v  = '0;
        en_clr_v  = '0;
        pd_set_v  = '0;
        pd_clr_v  = '0;
        prio_wr_v = '0;
        tgt_wr_v  = '0;
        if (bus_wr) begin
            unique case (addr_e)
                RA_EN_SET: en_set_v  = bus_wdata[NUM_IRQ-1:0];
                RA_EN_CLR: en_clr_v  = bus_wdata[NUM_IRQ-1:0];
                RA_PD_SET: pd_set_v  = bus_wdata[NUM_IRQ-1:0];
                RA_PD_CLR: pd_clr_v  = bus_wdata[NUM_IRQ-1:0];
                RA_PRIO:   prio_wr_v[sel_idx] = 1'b1;
                RA_TGT:    tgt_wr_v[sel_idx]  = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr_e)
            RA_CTRL:   bus_rdata = DATA_W'(fwd_en);
            RA_TYPE:   bus_rdata = TYPE_VAL;
            RA_EN_SET,
            RA_EN_CLR: bus_rdata = DATA_W'(en_vec);
            RA_PD_SET,
            RA_PD_CLR: bus_rdata = DATA_W'(pend_vec);
            RA_ACTIVE: bus_rdata = DATA_W'(act_vec);
            RA_SEL:    bus_rdata = DATA_W'(sel_idx);
            RA_PRIO:   bus_rdata = DATA_W'(sel_prio);
            RA_TGT:    bus_rdata = DATA_W'(sel_tgt);
            RA_STAT:   bus_rdata = DATA_W'(sel_stat);
            default:   bus_rdata = '0;
        endcase
    end

    // R5
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_CTRL) |=> (fwd_en == $past(bus_wdata[0])));
    // R2
    set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_v & en_clr_v) == '0);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import idist_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CPU = 4,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_line,
    input  logic                      bus_wr,
    input  logic [3:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [NUM_CPU-1:0]        cpu_valid,
    output logic [NUM_CPU*ID_W-1:0]   cpu_id,
    output logic [NUM_CPU*8-1:0]      cpu_prio,
    input  logic [NUM_CPU-1:0]        cpu_ack,
    input  logic [NUM_CPU-1:0]        cpu_eoi,
    input  logic [NUM_CPU*ID_W-1:0]   cpu_eoi_id
);
    logic                      fwd_en;
    logic [ID_W-1:0]           sel_idx;
    logic [NUM_IRQ-1:0]        en_set_v, en_clr_v, pd_set_v, pd_clr_v;
    logic [NUM_IRQ-1:0]        prio_wr_v, tgt_wr_v;
    logic [NUM_IRQ-1:0]        en_v, pend_v, act_v, ack_v, deact_v;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic [TGT_W-1:0]          tgt_a  [NUM_IRQ];
    logic [1:0]                stat_a [NUM_IRQ];

    idist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .en_vec(en_v), .pend_vec(pend_v), .act_vec(act_v),
        .sel_prio(prio_flat[sel_idx*PRIO_W +: PRIO_W]),
        .sel_tgt(tgt_a[sel_idx]), .sel_stat(stat_a[sel_idx]),
        .fwd_en(fwd_en), .sel_idx(sel_idx),
        .en_set_v(en_set_v), .en_clr_v(en_clr_v),
        .pd_set_v(pd_set_v), .pd_clr_v(pd_clr_v),
        .prio_wr_v(prio_wr_v), .tgt_wr_v(tgt_wr_v)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
        idist_slot u_slot (
            .clk(clk), .rst_n(rst_n), .line(irq_line[i]),
            .en_set(en_set_v[i]), .en_clr(en_clr_v[i]),
            .pd_set(pd_set_v[i]), .pd_clr(pd_clr_v[i]),
            .prio_wr(prio_wr_v[i]), .tgt_wr(tgt_wr_v[i]),
            .wbyte(bus_wdata[7:0]),
            .ack(ack_v[i]), .deact(deact_v[i]),
            .enabled(en_v[i]), .pending(pend_v[i]), .active(act_v[i]),
            .prio(prio_flat[i*PRIO_W +: PRIO_W]),
            .target(tgt_a[i]), .status(stat_a[i])
        );
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0] cand;
        always_comb begin
            for (int i = 0; i < NUM_IRQ; i++)
                cand[i] = fwd_en & en_v[i] & pend_v[i] & ~act_v[i] & tgt_a[i][c];
        end

        idist_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
            .clk(clk), .rst_n(rst_n),
            .cand(cand), .prio_flat(prio_flat),
            .valid(cpu_valid[c]),
            .win_id(cpu_id[c*ID_W +: ID_W]),
            .win_prio(cpu_prio[c*8 +: 8])
        );

        // R6
        tgt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_valid[c] |-> tgt_a[cpu_id[c*ID_W +: ID_W]][c]);
    end

    always_comb begin
        ack_v   = '0;
        deact_v = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (cpu_ack[c] && cpu_valid[c]) ack_v[cpu_id[c*ID_W +: ID_W]] = 1'b1;
            if (cpu_eoi[c]) deact_v[cpu_eoi_id[c*ID_W +: ID_W]] = 1'b1;
        end
    end

    // R5
    fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (cpu_valid == '0));
endmodule

// File: tb/irq_distributor_bench.sv
module irq_distributor_bench;
    localparam int NI = 32;
    localparam int NC = 4;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   irq_line = '0;
    logic            bus_wr = 1'b0;
    logic [3:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   cpu_valid;
    logic [NC*IW-1:0] cpu_id;
    logic [NC*8-1:0] cpu_prio;
    logic [NC-1:0]   cpu_ack = '0;
    logic [NC-1:0]   cpu_eoi = '0;
    logic [NC*IW-1:0] cpu_eoi_id = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC)) u_irq_distributor (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_valid(cpu_valid), .cpu_id(cpu_id),
        .cpu_prio(cpu_prio), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi),
        .cpu_eoi_id(cpu_eoi_id)
    );

    // {tag number, write, address, data or expected read}
    localparam int NV = 27;
    localparam logic [40:0] VECS [NV] = '{
        {4'd10, 1'b0, 4'd1,  32'h0000_0420},  // R10 type word
        {4'd1,  1'b0, 4'd0,  32'h0},          // R1 forward off
        {4'd1,  1'b0, 4'd2,  32'h0},          // R1 all disabled
        {4'd1,  1'b0, 4'd4,  32'h0},          // R1 none pending
        {4'd1,  1'b0, 4'd6,  32'h0},          // R1 none active
        {4'd1,  1'b0, 4'd8,  32'h7F},         // R1 reset priority
        {4'd1,  1'b0, 4'd9,  32'h01},         // R1 reset target
        {4'd2,  1'b1, 4'd2,  32'h0000_00F0},
        {4'd2,  1'b0, 4'd2,  32'h0000_00F0},  // R2 set
        {4'd2,  1'b1, 4'd3,  32'h0000_0030},
        {4'd2,  1'b0, 4'd3,  32'h0000_00C0},  // R2 clear only ones
        {4'd2,  1'b1, 4'd2,  32'h8000_0001},
        {4'd2,  1'b0, 4'd2,  32'h8000_00C1},  // R2 set keeps others
        {4'd3,  1'b1, 4'd4,  32'h0000_0105},
        {4'd3,  1'b0, 4'd4,  32'h0000_0105},  // R3 set pending
        {4'd3,  1'b1, 4'd5,  32'h0000_0004},
        {4'd3,  1'b0, 4'd5,  32'h0000_0101},  // R3 clear pending
        {4'd11, 1'b1, 4'd7,  32'd8},
        {4'd4,  1'b0, 4'd10, 32'h1},          // R4 status pending only
        {4'd11, 1'b1, 4'd8,  32'h10},
        {4'd11, 1'b0, 4'd8,  32'h10},         // R11 priority write
        {4'd11, 1'b1, 4'd9,  32'h06},
        {4'd11, 1'b0, 4'd9,  32'h06},         // R11 target write
        {4'd11, 1'b1, 4'd7,  32'd0},
        {4'd11, 1'b0, 4'd8,  32'h7F},         // R11 other line untouched
        {4'd11, 1'b0, 4'd9,  32'h01},         // R11 other line untouched
        {4'd5,  1'b0, 4'd6,  32'h0}           // R5 nothing active
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] id_of(input int c);
        return 32'(cpu_id[c*IW +: IW]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 no cpu valid", 32'(cpu_valid), 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k][36]) wr(VECS[k][35:32], VECS[k][31:0]);
            else begin
                rd(VECS[k][35:32], r);
                check($sformatf("R%0d vector %0d", VECS[k][40:37], k), r, VECS[k][31:0]);
            end
        end

        // fresh state for directed tests
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R5: forwarding gate
        wr(4'd2, 32'h8); wr(4'd4, 32'h8);
        @(negedge clk);
        check("R5 gated when off", 32'(cpu_valid), 32'h0);
        wr(4'd0, 32'h1);
        @(negedge clk);
        check("R5 cpu0 valid", 32'(cpu_valid), 32'h1);
        check("R5 cpu0 id", id_of(0), 32'd3);

        // R6: target mask
        wr(4'd7, 32'd3); wr(4'd9, 32'h06);
        @(negedge clk);
        check("R6 targets cpu1 cpu2", 32'(cpu_valid), 32'h6);
        check("R6 cpu2 id", id_of(2), 32'd3);
        wr(4'd9, 32'h01);

        // R7: priority and tie-break
        wr(4'd2, 32'h220); wr(4'd4, 32'h220);
        @(negedge clk);
        check("R7 tie lowest id", id_of(0), 32'd3);
        wr(4'd7, 32'd9); wr(4'd8, 32'h20);
        @(negedge clk);
        check("R7 lower value wins", id_of(0), 32'd9);
        check("R7 offered prio", 32'(cpu_prio[7:0]), 32'h20);
        wr(4'd7, 32'd5); wr(4'd8, 32'h20);
        @(negedge clk);
        check("R7 tie at 0x20", id_of(0), 32'd5);

        // R8: acknowledge
        @(negedge clk); cpu_ack[0] = 1'b1;
        @(negedge clk); cpu_ack[0] = 1'b0;
        rd(4'd10, r);
        check("R8 status active", r, 32'h2);
        check("R8 next offer", id_of(0), 32'd9);
        rd(4'd6, r);
        check("R8 active vector", r, 32'h20);
        irq_line[5] = 1'b1;
        rd(4'd10, r);
        check("R8 level hidden while active", r, 32'h2);
        wr(4'd4, 32'h20);
        rd(4'd10, r);
        check("R4 pending and active", r, 32'h3);

        // R9: end of interrupt from another CPU
        @(negedge clk); cpu_eoi[2] = 1'b1; cpu_eoi_id[2*IW +: IW] = 5'd5;
        @(negedge clk); cpu_eoi[2] = 1'b0;
        rd(4'd10, r);
        check("R9 inactive pending", r, 32'h1);
        check("R9 offered again", id_of(0), 32'd5);
        wr(4'd5, 32'h20);
        rd(4'd10, r);
        check("R3 level survives clear", r, 32'h1);
        irq_line[5] = 1'b0;
        rd(4'd10, r);
        check("R3 level dropped", r, 32'h0);
        check("R3 offer moves on", id_of(0), 32'd9);

        // R2: disable removes from offer
        wr(4'd3, 32'h200);
        @(negedge clk);
        check("R2 disabled skipped", id_of(0), 32'd3);
        check("R2 prio of line 3", 32'(cpu_prio[7:0]), 32'h7F);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule